// File: doc/BRIEF.md
# External Interrupt Sense and Vector Unit

This unit gathers up to eight active-low external interrupt request pins and turns them into one request line toward a processor, together with a vector code that names the winning source. Each pin is sensed either as a low level or as a falling edge. Edge events are captured in a pending register that software clears by writing ones. Level events are never latched; they follow the pin.

Software reaches four 32-bit word registers over a plain single-cycle register bus. These hold the per-line sense selection, the per-line enable mask and the pending bits, plus a read-only vector word. When several enabled sources are active at once, the lowest-numbered line wins. The vector code is that line number plus a fixed non-zero base, and zero means that nothing is requesting.

Top module: `ext_irq_sense_vec`

## Requirements
- R1: Inputs are active low. A line in low-level mode with its enable set raises `irq_req_o` on the third rising clock edge after the pin goes low, and drops it on the third rising edge after the pin returns high.
- R2: The sense word sits at word index 0. Line n uses bit 15−n (line 0 at bit 15, line 7 at bit 8). A 1 selects falling-edge sensing and a 0 selects low-level sensing. All other bits read as 0.
- R3: The enable word sits at word index 1. Line k uses bit 31−k, and a 1 enables the line. While a line's enable bit is 0, the line does not contribute to the request or to the vector.
- R4: For a line in edge mode, a high-to-low transition of the synchronised pin sets its pending bit. Pending bits sit at word index 2, line k at bit 31−k, and all other bits read 0. This happens whether or not the line is enabled.
- R5: Writing word index 2 clears every pending bit written as 1 and leaves bits written as 0 unchanged. Lines in level mode never show a pending bit.
- R6: Word index 3 is read-only. Its bits 6:0 give VEC_BASE+n for the winning line n, or 0 when no enabled source is active. All other bits read 0.
- R7: When several enabled sources are active, the lowest line number wins the vector.
- R8: If a falling edge is detected in the same cycle as a write-one-to-clear of that bit, the bit stays set.
- R9: `irq_req_o` is the OR of all enabled active sources. It changes on the rising edge that follows the register write that changed it.
- R10: After reset the sense, enable and pending words, the vector and `irq_req_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_n_i | input | NLINES | External request pins, active low, asynchronous |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | Write strobe when selected |
| bus_word_i | input | 2 | Word index of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the word index |
| irq_req_o | output | 1 | Registered request to the processor |

## Verification
The case that is hardest to reach from the ports is a falling edge that reaches the detector in exactly the cycle in which software clears the same pending bit. The pin passes through a synchroniser first, so the bench counts the two flop stages. It drops the pin on a falling clock edge and places the clearing write on the third rising edge after that. It then reads the pending word to confirm that the bit survived. Random pin, sense, enable and clear traffic runs alongside this case and is compared with a line-indexed reference model in the bench.

// File: rtl/ext_irq_sense_vec.sv
module ext_irq_sense_vec #(
  parameter int         NLINES   = 8,      // at most 8: sense bits occupy 15..8
  parameter logic [6:0] VEC_BASE = 7'd64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_n_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [1:0]        bus_word_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_req_o
);
  localparam logic [1:0] W_SENSE = 2'd0, W_EN = 2'd1, W_PEND = 2'd2, W_VEC = 2'd3;

  logic [NLINES-1:0] s1, s2, s3, edge_cfg, en, pend;
  logic [NLINES-1:0] fall, clr, act, hit, sense_w, en_w;
  logic [6:0]        vec_q, vec_d;
  logic              req_q;
  logic              unused_bits;

  wire wr = bus_sel_i && bus_wr_i;
  assign unused_bits = ^bus_wdata_i;

  assign fall = s3 & ~s2;
  assign act  = (edge_cfg & pend) | (~edge_cfg & ~s2);
  assign hit  = en & act;

  always_comb begin
    for (int k = 0; k < NLINES; k++) begin
      sense_w[k] = bus_wdata_i[15-k];
      en_w[k]    = bus_wdata_i[31-k];
      clr[k]     = wr && (bus_word_i == W_PEND) && bus_wdata_i[31-k];
    end
    vec_d = 7'd0;
    for (int k = NLINES-1; k >= 0; k--)
      if (hit[k]) vec_d = VEC_BASE + 7'(k);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '1; s2 <= '1; s3 <= '1;
      edge_cfg <= '0; en <= '0; pend <= '0;
      vec_q <= 7'd0; req_q <= 1'b0;
    end else begin
      s1 <= irq_n_i; s2 <= s1; s3 <= s2;
      if (wr && bus_word_i == W_SENSE) edge_cfg <= sense_w;
      if (wr && bus_word_i == W_EN)    en <= en_w;
      pend  <= ((pend & ~clr) | (fall & edge_cfg)) & edge_cfg;
      vec_q <= vec_d;
      req_q <= |hit;
    end
  end

  always_comb begin
    bus_rdata_o = 32'd0;
    case (bus_word_i)
      W_SENSE: for (int k = 0; k < NLINES; k++) bus_rdata_o[15-k] = edge_cfg[k];
      W_EN:    for (int k = 0; k < NLINES; k++) bus_rdata_o[31-k] = en[k];
      W_PEND:  for (int k = 0; k < NLINES; k++) bus_rdata_o[31-k] = pend[k];
      W_VEC:   bus_rdata_o[6:0] = vec_q;
      default: bus_rdata_o = 32'd0;
    endcase
  end

  assign irq_req_o = req_q;

  // R4 and R8: a detected edge is held even against a same-cycle clear
  p_edge_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fall & edge_cfg) != '0 |=> (pend & $past(fall & edge_cfg)) == $past(fall & edge_cfg));

  p_w1c_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_word_i == W_PEND) |=> (pend & $past(clr & ~(fall & edge_cfg))) == '0);

  p_req_vec_agree_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o == (vec_q != 7'd0));

  p_vec_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_q != 7'd0 |-> (vec_q >= VEC_BASE && vec_q < VEC_BASE + 7'(NLINES)));

  p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en == '0 |=> !irq_req_o);
endmodule

// File: tb/ext_irq_sense_vec_tb.sv
module ext_irq_sense_vec_tb_top;
  localparam int         N    = 8;
  localparam logic [6:0] BASE = 7'd64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] irq_n = '1;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_word = 2'd0;
  logic [31:0] bus_wdata = 32'd0, bus_rdata;
  logic irq_req;

  int n_chk = 0, n_bad = 0;
  logic [N-1:0] m_cfg = '0, m_en = '0, m_pend = '0;

  always #4 clk = ~clk;

  ext_irq_sense_vec #(.NLINES(N), .VEC_BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_n_i(irq_n), .bus_sel_i(bus_sel), .bus_wr_i(bus_wr),
    .bus_word_i(bus_word), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_req_o(irq_req));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] msb_word(input logic [N-1:0] v);
    logic [31:0] w = 32'd0;
    for (int k = 0; k < N; k++) w[31-k] = v[k];
    return w;
  endfunction

  function automatic logic [31:0] sense_word(input logic [N-1:0] v);
    logic [31:0] w = 32'd0;
    for (int k = 0; k < N; k++) w[15-k] = v[k];
    return w;
  endfunction

  function automatic logic [N-1:0] from_msb(input logic [31:0] w);
    logic [N-1:0] v;
    for (int k = 0; k < N; k++) v[k] = w[31-k];
    return v;
  endfunction

  function automatic logic [N-1:0] from_sense(input logic [31:0] w);
    logic [N-1:0] v;
    for (int k = 0; k < N; k++) v[k] = w[15-k];
    return v;
  endfunction

  function automatic logic [6:0] exp_vec();
    logic [N-1:0] a = m_en & ((m_cfg & m_pend) | (~m_cfg & ~irq_n));
    for (int k = 0; k < N; k++) if (a[k]) return BASE + 7'(k);
    return 7'd0;
  endfunction

  // tasks start and end near a falling clock edge
  task automatic bwrite(input logic [1:0] w, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_word = w; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [1:0] w, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_word = w;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    logic [6:0] ev = exp_vec();
    check({tag, " R9 irq_req"}, {31'd0, irq_req}, {31'd0, ev != 7'd0});
    bread(2'd3, d); check({tag, " R6 vector"}, d, {25'd0, ev});
    bread(2'd2, d); check({tag, " R4 pending"}, d, msb_word(m_pend));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq_n = '1; idle(3); rst_n = 1'b1; idle(1);
    m_cfg = '0; m_en = '0; m_pend = '0;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();

    // R10 reset state
    check("R10 irq_req", {31'd0, irq_req}, 32'd0);
    for (int w = 0; w < 4; w++) begin
      bread(2'(w), d); check("R10 register", d, 32'd0);
    end

    // R2 only sense bits are stored
    bwrite(2'd0, 32'hFFFF_FFFF);
    bread(2'd0, d); check("R2 sense readback", d, 32'h0000_FF00);
    bwrite(2'd0, 32'h0000_4000);
    bread(2'd0, d); check("R2 line1 edge bit14", d, 32'h0000_4000);
    bwrite(2'd0, 32'd0);

    // R3 masked level source, then R9 timing on enable write
    irq_n[3] = 1'b0; idle(5);
    check("R3 masked stays quiet", {31'd0, irq_req}, 32'd0);
    bwrite(2'd1, 32'h1000_0000); m_en = 8'h08;
    check("R9 not yet after write", {31'd0, irq_req}, 32'd0);
    idle(1);
    check("R9 one clock after write", {31'd0, irq_req}, 32'd1);
    bread(2'd3, d); check("R6 vector line3", d, {25'd0, BASE + 7'd3});
    bread(2'd2, d); check("R5 level has no pending", d, 32'd0);

    // R1 level drop latency
    irq_n[3] = 1'b1; idle(2);
    check("R1 still high after two edges", {31'd0, irq_req}, 32'd1);
    idle(1);
    check("R1 dropped on third edge", {31'd0, irq_req}, 32'd0);

    // R7 lowest line wins
    bwrite(2'd1, 32'hFF00_0000); m_en = '1;
    irq_n[5] = 1'b0; irq_n[2] = 1'b0; idle(5);
    bread(2'd3, d); check("R7 lowest wins", d, {25'd0, BASE + 7'd2});
    irq_n = '1; idle(5);
    check("R1 all high quiet", {31'd0, irq_req}, 32'd0);

    // R4 edge on line 6 while masked latches
    bwrite(2'd1, 32'd0); m_en = '0;
    bwrite(2'd0, 32'h0000_0200); m_cfg = 8'h40;
    irq_n[6] = 1'b0; idle(5); irq_n[6] = 1'b1; idle(5);
    bread(2'd2, d); check("R4 masked edge latched", d, 32'h0200_0000);
    check("R3 masked edge no request", {31'd0, irq_req}, 32'd0);

    // R8 new edge in the clearing cycle keeps the bit
    irq_n[6] = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    bwrite(2'd2, 32'h0200_0000);
    bread(2'd2, d); check("R8 edge beats clear", d, 32'h0200_0000);
    bwrite(2'd2, 32'h0200_0000);
    bread(2'd2, d); check("R5 clear without edge", d, 32'd0);
    irq_n[6] = 1'b1; idle(4);

    // random traffic against the model
    do_reset();
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 5) begin
        logic [N-1:0] nv = N'($urandom);
        m_pend |= m_cfg & irq_n & ~nv;
        irq_n = nv;
      end else if (op == 5) begin
        logic [31:0] w = $urandom;
        bwrite(2'd0, w); m_cfg = from_sense(w); m_pend &= m_cfg;
      end else if (op < 8) begin
        logic [31:0] w = $urandom;
        bwrite(2'd1, w); m_en = from_msb(w);
      end else begin
        logic [31:0] w = $urandom;
        bwrite(2'd2, w); m_pend &= ~from_msb(w);
      end
      idle(5);
      check_all("random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule